// File: doc/BRIEF.md
# Serial Break Truncator

This block sits in the logic-level receive path between a differential line receiver and the input of an ordinary UART. It measures every continuous low stretch of the serial line with a tick counter. The counter is held at zero while the line is high. When a low stretch lasts longer than a fixed limit, the output is forced high for as long as the line stays low. A break of any length then reaches the UART as a low pulse of a fixed width, followed by a long mark.

The limit is set to ten bit times, which ends just after the first stop-bit position. A UART that keeps sampling on its own bit grid, without searching for a new start edge, sees exactly one framing error. The time removed from the break is added to the mark that follows it, so the UART gets at least one full idle byte time to realign before the first data byte. Ordinary characters never reach the limit and pass through untouched. The longest of them is an all-zero byte, which is nine bit times low.

The line input first passes through a synchroniser chain. A prescaler divides the system clock down to the counter tick, so the same block can be retimed for any clock frequency through two parameters.

Top module: `serial_break_trunc`

## Requirements
- R1: While the synchronised line is high, `uart_out` is high. `uart_out` follows `line_in` with a delay of exactly SYNC_STAGES clock cycles (2 by default).
- R2: A low stretch of at most TICK_DIV*TRUNC_COUNT clock cycles appears on `uart_out` unchanged, with the same length and delayed by SYNC_STAGES cycles.
- R3: A low stretch longer than TICK_DIV*TRUNC_COUNT cycles produces an output low of exactly TICK_DIV*TRUNC_COUNT cycles, after which `uart_out` goes high.
- R4: Once truncation has fired, `uart_out` stays high and the tick counter stays frozen for as long as the line stays low, with no upper bound on the length.
- R5: When the line returns high, the forced level is released and the counter is cleared. The next low stretch is timed from zero, and a short one passes unchanged.
- R6: While `rst_n` is low, `uart_out` is high whatever the value of `line_in`, and no truncation state remains after reset is released.
- R7: With TICK_DIV = 1 the prescaler is omitted and the limit is TRUNC_COUNT clock cycles. R2 to R5 hold with that limit.
- R8: A serial character with bit time TICK_DIV*TRUNC_COUNT/10 cycles passes unchanged for every data value, including 0x00. A character is one low start bit, 8 data bits LSB first (1 = high) and two high stop bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counter tick is this clock divided by TICK_DIV |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Serial data from the line receiver (high = mark) |
| uart_out | output | 1 | Reshaped serial data to the UART receive input |

## Verification
The bench sweeps every low-stretch length from a single cycle up to well past the limit, each followed by several mark lengths. This exposes an off-by-one limit, which would make the output low one cycle too long or too short at the boundary (R2, R3). It also exposes a prescaler that free-runs instead of restarting on each falling edge, which would make the truncated width vary with phase. A very long break checks that the counter does not wrap; a wrapping counter would release the forced high and send a second spurious low to the UART (R4). A break followed by a one-cycle mark and a short low checks that the counter is cleared (R5); stale state there would cut ordinary data. A stream of characters at the matched bit rate, including zero bytes, covers the case a limit set too tight would damage (R8). A second instance with no prescaler covers the other generate branch (R7).

// File: rtl/brk_trunc_pkg.sv
package brk_trunc_pkg;

  // Width of a counter that must hold values 0..limit inclusive.
  function automatic int unsigned count_width(input int unsigned limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

  // Width of a prescaler that counts 0..div-1.
  function automatic int unsigned div_width(input int unsigned div);
    return (div <= 1) ? 1 : $clog2(div);
  endfunction

  // Number of clock cycles of continuous low before truncation fires.
  function automatic int unsigned trunc_cycles(input int unsigned div,
                                               input int unsigned limit);
    return div * limit;
  endfunction

endpackage

// File: rtl/brk_sync.sv
module brk_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= RESET_VAL;
          else        chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= RESET_VAL;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/brk_tick_gen.sv
module brk_tick_gen #(
  parameter int unsigned DIV = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  import brk_trunc_pkg::*;
  localparam int unsigned PW = div_width(DIV);

  generate
    if (DIV <= 1) begin : g_direct
      // Every clock cycle of a running low stretch is one tick.
      assign tick = run;
    end else begin : g_div
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase;
      // Phase restarts on every stop, so ticks align to the falling edge.
      always_ff @(posedge clk) begin
        if (!rst_n || !run)   phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                  phase <= phase + 1'b1;
      end
      assign tick = run && (phase == LAST);
    end
  endgenerate
endmodule

// File: rtl/brk_low_timer.sv
module brk_low_timer #(
  parameter int unsigned LIMIT = 64,
  parameter int unsigned CW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_hi,
  input  logic          tick,
  output logic [CW-1:0] count,
  output logic          fired
);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  // Saturating tick counter: cleared by a mark, frozen at the limit.
  always_ff @(posedge clk) begin
    if (!rst_n || line_hi)     count <= '0;
    else if (tick && !fired)   count <= count + 1'b1;
  end

  assign fired = (count == TOP);
endmodule

// File: rtl/serial_break_trunc.sv
module serial_break_trunc #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TICK_DIV    = 30,
  parameter int unsigned TRUNC_COUNT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic uart_out
);
  import brk_trunc_pkg::*;
  localparam int unsigned CW = count_width(TRUNC_COUNT);

  // Named internal events, observed by the bound checker.
  logic          s_line;
  logic          tick;
  logic          fired;
  logic [CW-1:0] cnt;
  logic          run;

  brk_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (line_in),
    .q_out (s_line)
  );

  assign run = !s_line && !fired;

  brk_tick_gen #(.DIV(TICK_DIV)) i_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  brk_low_timer #(.LIMIT(TRUNC_COUNT), .CW(CW)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_hi (s_line),
    .tick    (tick),
    .count   (cnt),
    .fired   (fired)
  );

  // Both terms are flop outputs; fired only rises while s_line is steady low.
  assign uart_out = s_line | fired;
endmodule

// File: rtl/serial_break_trunc_chk.sv
module serial_break_trunc_chk #(
  parameter int unsigned CW          = 7,
  parameter int unsigned TRUNC_COUNT = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_line,
  input logic          tick,
  input logic          fired,
  input logic [CW-1:0] cnt,
  input logic          uart_out
);
  // R1
  line_high_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_line |-> uart_out);

  // R2
  short_low_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_line && !fired) |-> !uart_out);

  // R3
  fire_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_line && $rose(fired)) |-> $past(tick));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(TRUNC_COUNT));

  // R4
  hold_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fired && !s_line) |=> (s_line || fired));

  // R4
  frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fired && !s_line) |=> $stable(cnt));

  // R5
  release_on_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_line |=> (cnt == '0));
endmodule

bind serial_break_trunc serial_break_trunc_chk #(
  .CW(CW), .TRUNC_COUNT(TRUNC_COUNT)
) i_chk (
  .clk(clk), .rst_n(rst_n), .s_line(s_line), .tick(tick),
  .fired(fired), .cnt(cnt), .uart_out(uart_out)
);

// File: tb/test_serial_break_trunc.sv
`timescale 1ns/1ps
module test_serial_break_trunc;
  localparam int DIV_A = 2;
  localparam int LIM_A = 10;   // limit 20 cycles, bit time 2 cycles
  localparam int LIM_B = 5;    // no prescaler, limit 5 cycles
  localparam int CYC_A = DIV_A * LIM_A;
  localparam int CYC_B = LIM_B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_in = 1'b1;
  logic out_a, out_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit cmp_en = 1'b0;
  string tag_override = "";

  // Driven history: d1 = last negedge, d2 = the one before; matching runs.
  logic d1 = 1'b1, d2 = 1'b1;
  int   r0 = 0, r1 = 0, r2 = 0;
  bit   after_trunc_a = 0, after_trunc_b = 0;
  bit   cur_long_a = 0, cur_long_b = 0;

  always #2.5 clk = ~clk;

  serial_break_trunc #(.SYNC_STAGES(2), .TICK_DIV(DIV_A), .TRUNC_COUNT(LIM_A))
    i_serial_break_trunc (.clk(clk), .rst_n(rst_n), .line_in(line_in), .uart_out(out_a));

  serial_break_trunc #(.SYNC_STAGES(2), .TICK_DIV(1), .TRUNC_COUNT(LIM_B))
    i_serial_break_trunc_b (.clk(clk), .rst_n(rst_n), .line_in(line_in), .uart_out(out_b));

  // Expected output: delayed input, forced high once the low run exceeds the limit.
  function automatic logic expect_out(logic v, int run, int lim);
    return v | (run > lim);
  endfunction

  function automatic string pick_tag(logic v, int run, int lim, bit after);
    if (v) return "R1";
    if (run <= lim) return after ? "R5" : "R2";
    if (run == lim + 1) return "R3";
    return "R4";
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: uart_out=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: compare at the negedge, then drive the next input value.
  task automatic step(logic v);
    @(negedge clk);
    if (cmp_en) begin
      string ta, tb;
      ta = pick_tag(d2, r2, CYC_A, after_trunc_a);
      tb = "R7";
      if (tag_override != "") ta = tag_override;
      check(ta, out_a, expect_out(d2, r2, CYC_A));
      check(tb, out_b, expect_out(d2, r2, CYC_B));
      if (!d2) begin
        if (r2 > CYC_A) cur_long_a = 1;
        if (r2 > CYC_B) cur_long_b = 1;
      end else begin
        if (r2 == 0 && !$isunknown(d2)) begin
          after_trunc_a = cur_long_a ? 1'b1 : (r1 == 0 ? after_trunc_a : 1'b0);
          after_trunc_b = cur_long_b;
          cur_long_a = 0;
          cur_long_b = 0;
        end
      end
    end
    d2 = d1; r2 = r1;
    d1 = v;
    r1 = v ? 0 : r0 + 1;
    r0 = r1;
    line_in = v;
  endtask

  task automatic low_high(int l, int h);
    for (int i = 0; i < l; i++) step(1'b0);
    for (int i = 0; i < h; i++) step(1'b1);
  endtask

  task automatic send_byte(logic [7:0] b);
    localparam int BT = CYC_A / 10;
    for (int i = 0; i < BT; i++) step(1'b0);
    for (int k = 0; k < 8; k++)
      for (int i = 0; i < BT; i++) step(b[k]);
    for (int i = 0; i < 2 * BT; i++) step(1'b1);
  endtask

  initial begin
    repeat (5000000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R6: output high during reset even with the line low
    line_in = 1'b0;
    repeat (4) @(negedge clk);
    check("R6", out_a, 1'b1);
    check("R6", out_b, 1'b1);
    line_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R6", out_a, 1'b1);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    repeat (4) step(1'b1);

    // R6: a low stretch right after reset is timed from zero
    low_high(CYC_A, 3);

    // R2/R3/R4/R1/R7: sweep low lengths against several mark lengths
    for (int h = 1; h <= 4; h++)
      for (int l = 1; l <= CYC_A + 12; l++)
        low_high(l, h);

    // R4: very long break, counter must not wrap
    low_high(600, 1);
    // R5: one-cycle mark then short lows, timed from zero
    low_high(CYC_A, 2);
    low_high(300, 1);
    low_high(3, 5);

    // R8: characters at the matched bit rate, every data value
    tag_override = "R8";
    for (int b = 0; b < 256; b++) send_byte(8'(b));
    send_byte(8'h00);
    send_byte(8'h00);
    tag_override = "";
    low_high(CYC_A + 30, 6);
    repeat (4) step(1'b1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule